// File: doc/BRIEF.md
# Dual Alarm Match Unit

This unit watches the current time held by a separate BCD time counter and raises two alarms. The weekly alarm fires when minute and hour agree with its stored values and the current day of week is one of the days marked in a seven-bit day mask. This lets one alarm cover any set of days, such as three weekdays or a weekend. The daily alarm fires when minute and hour agree, on every day.

The time counter gives a one-cycle strobe whenever the minute changes. The unit checks for a match only on that strobe, so each alarm can fire at most once per minute. A small register port sets the alarm times, the two enables and the two flags. Each alarm keeps a sticky flag that drives its own active-low interrupt output. Software clears a flag by writing 0 to it. While an alarm is disabled, its flag reads 0 and its output stays high.

Top module: `alarm_pair_match`

## Requirements
- R1: The weekly alarm matches on a strobe when the minute is bit-equal to the 7-bit weekly minute register, the hour is bit-equal to the 6-bit weekly hour register, and the bit of the day mask selected by the 3-bit day-of-week input (values 0 to 6) is set. A day-of-week value of 7 never matches.
- R2: The daily alarm matches on a strobe when minute and hour are bit-equal to its own registers, whatever the day of week. Hour values use the time counter's 12/24 encoding, with bit 5 as the PM bit in 12-hour form, and are compared bitwise.
- R3: While an alarm's enable is 0, the alarm never fires, its flag reads 0 and its interrupt output is 1. Clearing the enable also discards a flag that was already set.
- R4: Matches are evaluated only in cycles where the minute strobe is high. For a strobe sampled at rising edge k, the flag reads 1 and the output is 0 from rising edge k+1 on, and not before. The output is low exactly when the flag reads 1.
- R5: Writing 0 to a flag bit clears that flag and releases its output. Writing 1 to a flag bit has no effect.
- R6: When a flag clear and a new match reach the flag at the same edge, the match wins and the flag stays set.
- R7: After reset, both enables and both flags are 0, both outputs are 1, and every alarm setting reads 0.
- R8: Register map, 3-bit address and 8-bit data: 0 weekly minute [6:0], 1 weekly hour [5:0], 2 day mask [6:0] (bit n is day n), 3 daily minute [6:0], 4 daily hour [5:0], 5 enables (bit 0 weekly, bit 1 daily), 6 flags (bit 0 weekly, bit 1 daily). Unused bits and address 7 read 0. Reads are combinational.
- R9: A set flag stays set until it is cleared by a write or by its enable going to 0, even across later strobes that do not match.
- R10: The two alarms are independent. A match, a clear or an enable change on one alarm leaves the other alarm's flag and output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| min_tick | input | 1 | One-cycle strobe at each minute change |
| now_min | input | 7 | Current minute, BCD |
| now_hour | input | 6 | Current hour, BCD, with PM bit in 12-hour form |
| now_dow | input | 3 | Current day of week, 0 to 6 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_week_n | output | 1 | Weekly alarm interrupt, active low |
| irq_day_n | output | 1 | Daily alarm interrupt, active low |

## Verification
The assertions check on every cycle the one-cycle flag latency after a strobe and that a hit always wins over a clear. They also check that a clear releases a flag when no hit competes, that a flag is sticky while its alarm is enabled, that a disabled slot holds no flag, and that the flag read port agrees with the interrupt pins. Other behaviour can only be shown by the bench's scenarios. These are the full day-mask decode for several masks and every day value, and sweeps of every valid minute and hour against the daily alarm. They also cover the PM bit, ignored writes of 1, and the independence of the two alarms.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;
  localparam int unsigned MIN_W  = 7;
  localparam int unsigned HOUR_W = 6;
  localparam int unsigned DOW_W  = 3;
  localparam int unsigned DAYS   = 7;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SLOTS  = 2;

  typedef logic [MIN_W-1:0]  bcd_min_t;
  typedef logic [HOUR_W-1:0] bcd_hour_t;
  typedef logic [DOW_W-1:0]  dow_t;
  typedef logic [DAYS-1:0]   day_mask_t;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_data_t;

  localparam reg_addr_t AD_WK_MIN  = 3'd0;
  localparam reg_addr_t AD_WK_HOUR = 3'd1;
  localparam reg_addr_t AD_WK_DAYS = 3'd2;
  localparam reg_addr_t AD_DY_MIN  = 3'd3;
  localparam reg_addr_t AD_DY_HOUR = 3'd4;
  localparam reg_addr_t AD_ENABLE  = 3'd5;
  localparam reg_addr_t AD_FLAGS   = 3'd6;

  localparam int unsigned SLOT_WEEK = 0;
  localparam int unsigned SLOT_DAY  = 1;

  function automatic logic clock_equal(bcd_min_t a_min, bcd_hour_t a_hour,
                                       bcd_min_t c_min, bcd_hour_t c_hour);
    return (a_min == c_min) && (a_hour == c_hour);
  endfunction

  function automatic logic day_selected(day_mask_t mask, dow_t dow);
    logic r;
    r = 1'b0;
    for (int i = 0; i < DAYS; i++)
      if (dow == dow_t'(i)) r = mask[i];
    return r;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  reg_addr_t        reg_addr,
  input  reg_data_t        reg_wdata,
  input  logic [SLOTS-1:0] flag_vis,
  output reg_data_t        reg_rdata,
  output bcd_min_t         wk_min,
  output bcd_hour_t        wk_hour,
  output day_mask_t        wk_days,
  output bcd_min_t         dy_min,
  output bcd_hour_t        dy_hour,
  output logic [SLOTS-1:0] en,
  output logic [SLOTS-1:0] clr
);
  localparam int unsigned PAD_MIN  = DATA_W - MIN_W;
  localparam int unsigned PAD_HOUR = DATA_W - HOUR_W;
  localparam int unsigned PAD_DAYS = DATA_W - DAYS;
  localparam int unsigned PAD_SLOT = DATA_W - SLOTS;

  logic unused_wbit;
  assign unused_wbit = reg_wdata[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_min  <= '0;
      wk_hour <= '0;
      wk_days <= '0;
      dy_min  <= '0;
      dy_hour <= '0;
      en      <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AD_WK_MIN:  wk_min  <= reg_wdata[MIN_W-1:0];
        AD_WK_HOUR: wk_hour <= reg_wdata[HOUR_W-1:0];
        AD_WK_DAYS: wk_days <= reg_wdata[DAYS-1:0];
        AD_DY_MIN:  dy_min  <= reg_wdata[MIN_W-1:0];
        AD_DY_HOUR: dy_hour <= reg_wdata[HOUR_W-1:0];
        AD_ENABLE:  en      <= reg_wdata[SLOTS-1:0];
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_clr
      assign clr[g] = reg_we && (reg_addr == AD_FLAGS) && !reg_wdata[g];
    end
  endgenerate

  always_comb begin
    case (reg_addr)
      AD_WK_MIN:  reg_rdata = {{PAD_MIN{1'b0}}, wk_min};
      AD_WK_HOUR: reg_rdata = {{PAD_HOUR{1'b0}}, wk_hour};
      AD_WK_DAYS: reg_rdata = {{PAD_DAYS{1'b0}}, wk_days};
      AD_DY_MIN:  reg_rdata = {{PAD_MIN{1'b0}}, dy_min};
      AD_DY_HOUR: reg_rdata = {{PAD_HOUR{1'b0}}, dy_hour};
      AD_ENABLE:  reg_rdata = {{PAD_SLOT{1'b0}}, en};
      AD_FLAGS:   reg_rdata = {{PAD_SLOT{1'b0}}, flag_vis};
      default:    reg_rdata = '0;
    endcase
  end

  // R3: enable write takes effect at the next edge only
  a_r3_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AD_ENABLE) |=> (en == $past(reg_wdata[SLOTS-1:0])));
endmodule

// File: rtl/alarm_slot.sv
module alarm_slot
  import alarm_unit_pkg::*;
#(
  parameter bit USE_DAYS = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  bcd_min_t  now_min,
  input  bcd_hour_t now_hour,
  input  dow_t      now_dow,
  input  bcd_min_t  set_min,
  input  bcd_hour_t set_hour,
  input  day_mask_t set_days,
  input  logic      en,
  input  logic      clr,
  output logic      flag_vis
);
  logic day_ok;
  logic match_now;
  logic hit_q;
  logic flag_q;

  generate
    if (USE_DAYS) begin : g_week
      assign day_ok = day_selected(set_days, now_dow);
    end else begin : g_daily
      logic unused_day;
      assign unused_day = ^{set_days, now_dow};
      assign day_ok = 1'b1;
    end
  endgenerate

  assign match_now = clock_equal(set_min, set_hour, now_min, now_hour) && day_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= tick && en && match_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (!en)    flag_q <= 1'b0;
    else if (hit_q)  flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  assign flag_vis = flag_q && en;

  a_r4_strobe_gates_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !hit_q);
  a_r4_set_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick, 2));
  a_r6_hit_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && en) |=> flag_q);
  a_r5_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr && !hit_q) |=> !flag_q);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && en && !clr) |=> flag_q);
  a_r3_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag_q);
endmodule

// File: rtl/alarm_pair_match.sv
module alarm_pair_match
  import alarm_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        min_tick,
  input  logic [6:0]  now_min,
  input  logic [5:0]  now_hour,
  input  logic [2:0]  now_dow,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_week_n,
  output logic        irq_day_n
);
  bcd_min_t         wk_min, dy_min;
  bcd_hour_t        wk_hour, dy_hour;
  day_mask_t        wk_days;
  logic [SLOTS-1:0] en, clr, flag_vis;
  bcd_min_t         slot_min  [SLOTS];
  bcd_hour_t        slot_hour [SLOTS];

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flag_vis(flag_vis), .reg_rdata(reg_rdata),
    .wk_min(wk_min), .wk_hour(wk_hour), .wk_days(wk_days),
    .dy_min(dy_min), .dy_hour(dy_hour),
    .en(en), .clr(clr)
  );

  assign slot_min[SLOT_WEEK]  = wk_min;
  assign slot_hour[SLOT_WEEK] = wk_hour;
  assign slot_min[SLOT_DAY]   = dy_min;
  assign slot_hour[SLOT_DAY]  = dy_hour;

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      alarm_slot #(.USE_DAYS(s == SLOT_WEEK)) u_slot (
        .clk(clk), .rst_n(rst_n), .tick(min_tick),
        .now_min(now_min), .now_hour(now_hour), .now_dow(now_dow),
        .set_min(slot_min[s]), .set_hour(slot_hour[s]), .set_days(wk_days),
        .en(en[s]), .clr(clr[s]), .flag_vis(flag_vis[s])
      );
    end
  endgenerate

  assign irq_week_n = !flag_vis[SLOT_WEEK];
  assign irq_day_n  = !flag_vis[SLOT_DAY];

  // R8: flag register read agrees with the interrupt pins
  a_r8_flag_read_port: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AD_FLAGS) |-> (reg_rdata[1:0] == {!irq_day_n, !irq_week_n}));
endmodule

// File: tb/alarm_pair_match_tb.sv
module alarm_pair_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       min_tick = 1'b0;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic [2:0] now_dow = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_week_n, irq_day_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alarm_pair_match u_dut (
    .clk(clk), .rst_n(rst_n), .min_tick(min_tick),
    .now_min(now_min), .now_hour(now_hour), .now_dow(now_dow),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_week_n(irq_week_n), .irq_day_n(irq_day_n)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // flags read as {day, week}; pins merged the same way, active high
  task automatic pins(output logic [7:0] p);
    p = {6'b0, !irq_day_n, !irq_week_n};
  endtask

  // strobe with the given time; returns flags one cycle and two cycles on
  task automatic strobe(logic [6:0] m, logic [5:0] h, logic [2:0] d,
                        output logic [7:0] mid, output logic [7:0] fin);
    @(negedge clk);
    now_min = m; now_hour = h; now_dow = d; min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
    rd(3'd6, mid);
    @(negedge clk);
    rd(3'd6, fin);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, mid, fin, p;
    logic [6:0] masks [5];
    masks[0] = 7'h01; masks[1] = 7'h15; masks[2] = 7'h41;
    masks[3] = 7'h7F; masks[4] = 7'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R7 reset register", v, 8'h00);
    end
    pins(p);
    chk("R7 reset pins", p, 8'h00);

    // R8 register map and widths
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R8 wk minute width", v, 8'h7F);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R8 wk hour width", v, 8'h3F);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R8 day mask width", v, 8'h7F);
    wr(3'd3, 8'hA5); rd(3'd3, v); chk("R8 dy minute", v, 8'h25);
    wr(3'd4, 8'hC9); rd(3'd4, v); chk("R8 dy hour", v, 8'h09);
    wr(3'd7, 8'hFF); rd(3'd7, v); chk("R8 hole reads zero", v, 8'h00);
    rd(3'd5, v); chk("R8 enables untouched", v, 8'h00);

    // R3 disabled alarms never fire
    wr(3'd0, bcd(30)); wr(3'd1, bcd(6)); wr(3'd2, 8'h7F);
    wr(3'd3, bcd(30)); wr(3'd4, bcd(6));
    strobe(7'(bcd(30)), 6'(bcd(6)), 3'd2, mid, fin);
    chk("R3 disabled no flag", fin, 8'h00);
    pins(p); chk("R3 disabled pins high", p, 8'h00);

    // R1 weekly day-mask sweep, daily disabled (R10)
    wr(3'd5, 8'h01);
    wr(3'd0, bcd(15)); wr(3'd1, bcd(8));
    foreach (masks[i]) begin
      wr(3'd2, {1'b0, masks[i]});
      for (int d = 0; d < 8; d++) begin
        logic e;
        e = (d < 7) && masks[i][d];
        strobe(7'(bcd(15)), 6'(bcd(8)), 3'(d), mid, fin);
        chk("R4 latency weekly", mid, 8'h00);
        chk("R1 day mask", fin, {7'b0, e});
        pins(p); chk("R4 R10 pins weekly", p, {7'b0, e});
        wr(3'd6, 8'h00);
      end
    end
    wr(3'd2, 8'h7F);
    strobe(7'(bcd(16)), 6'(bcd(8)), 3'd1, mid, fin);
    chk("R1 minute mismatch", fin, 8'h00);
    strobe(7'(bcd(15)), 6'(bcd(9)), 3'd1, mid, fin);
    chk("R1 hour mismatch", fin, 8'h00);

    // R2 daily sweeps, weekly disabled
    wr(3'd5, 8'h02);
    wr(3'd3, bcd(45)); wr(3'd4, bcd(7));
    for (int m = 0; m < 60; m++) begin
      strobe(7'(bcd(m)), 6'(bcd(7)), 3'(m % 8), mid, fin);
      chk("R2 minute sweep", fin, (m == 45) ? 8'h02 : 8'h00);
      wr(3'd6, 8'h00);
    end
    for (int h = 0; h < 24; h++) begin
      strobe(7'(bcd(45)), 6'(bcd(h)), 3'(h % 8), mid, fin);
      chk("R2 hour sweep", fin, (h == 7) ? 8'h02 : 8'h00);
      wr(3'd6, 8'h00);
    end
    // R2 PM bit (bit 5) is compared bitwise
    wr(3'd4, 8'h32);
    strobe(7'(bcd(45)), 6'h12, 3'd0, mid, fin);
    chk("R2 AM vs PM", fin, 8'h00);
    strobe(7'(bcd(45)), 6'h32, 3'd0, mid, fin);
    chk("R2 PM match", fin, 8'h02);
    wr(3'd6, 8'h00);

    // R4 no strobe, no match
    @(negedge clk);
    now_min = 7'(bcd(45)); now_hour = 6'h32;
    repeat (5) @(negedge clk);
    rd(3'd6, v); chk("R4 no strobe no flag", v, 8'h00);

    // both alarms same time
    wr(3'd5, 8'h03);
    wr(3'd0, bcd(0)); wr(3'd1, bcd(12)); wr(3'd2, 8'h7F);
    wr(3'd3, bcd(0)); wr(3'd4, bcd(12));
    strobe(7'(bcd(0)), 6'(bcd(12)), 3'd3, mid, fin);
    chk("R4 latency both", mid, 8'h00);
    chk("R1 R2 both fire", fin, 8'h03);

    // R9 sticky across idle and non-matching strobes
    repeat (20) @(negedge clk);
    strobe(7'(bcd(1)), 6'(bcd(12)), 3'd3, mid, fin);
    chk("R9 sticky", fin, 8'h03);
    // R5 writing ones is ignored
    wr(3'd6, 8'hFF); rd(3'd6, v); chk("R5 write one ignored", v, 8'h03);
    // R5 R10 clear weekly only
    wr(3'd6, 8'h02); rd(3'd6, v); chk("R5 R10 clear weekly only", v, 8'h02);
    pins(p); chk("R5 pins after clear", p, 8'h02);

    // R3 disabling daily discards its flag; weekly unaffected (R10)
    wr(3'd5, 8'h01); rd(3'd6, v); chk("R3 disable hides flag", v, 8'h00);
    pins(p); chk("R3 disable pin high", p, 8'h00);
    wr(3'd5, 8'h03); rd(3'd6, v); chk("R3 reenable stays clear", v, 8'h00);

    // R6 clear and hit at the same edge: hit wins
    @(negedge clk);
    now_min = 7'(bcd(0)); now_hour = 6'(bcd(12)); now_dow = 3'd5; min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h00;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd6, v); chk("R6 set wins from clear", v, 8'h03);
    // R6 again with flags already set
    @(negedge clk);
    min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h00;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd6, v); chk("R6 set wins while set", v, 8'h03);
    wr(3'd6, 8'h00); rd(3'd6, v); chk("R5 clear both", v, 8'h00);
    pins(p); chk("R5 pins released", p, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule